// File: doc/BRIEF.md
# Explicit Branch Target Store

This block keeps eight numbered instruction lines that software fills ahead of a branch. A prefetch command names an entry and a 24-bit instruction address. The entry goes to the fetching state and a line request goes out to instruction memory. That request is tagged, so a reply for an older request of the same entry is thrown away. The reply carries eight 32-bit instructions, or an error. Either one settles the entry as valid or as faulted.

A branch command names an entry and carries the result of a condition that was evaluated elsewhere. When the branch is taken and the entry is valid, the entry's address and line become the instruction source on the next cycle. At the same moment a request for the next sequential line is raised for the double buffer. A taken branch to an entry that is still fetching stalls. A taken branch to an entry that is faulted or empty raises a trap instead.

Entries can only be saved and restored as neighbouring pairs, through a control-stack port that moves one pair per cycle. Calls and returns move a counted run of pairs automatically. An inter-module transfer wipes every entry.

Top module: `branch_target_store`

## Requirements
- R1: After reset every entry is empty, and no memory request, source load, trap, stack push or stack pop is active.
- R2: A prefetch on `pf_valid` sets the entry to fetching. The line request (`mreq_valid`, `mreq_id`, `mreq_addr`, `mreq_tag`) appears after the second rising edge following the command.
- R3: A reply whose id and tag match the entry's outstanding request makes the entry valid and stores the line (word w in bits 32w+31:32w), or makes the entry faulted when `mrsp_err` is 1.
- R4: A taken branch to a valid entry gives, after the next edge, a one-cycle `src_load` pulse with that entry's address and line. A branch that is not taken changes nothing.
- R5: `br_stall` is high in the same cycle as a taken branch to a fetching entry, and no source load follows.
- R6: A taken branch to a faulted or empty entry gives, after the next edge, a one-cycle `trap_valid` pulse with `trap_id` set to the entry, and no source load.
- R7: Along with `src_load`, `seq_req_valid` pulses, and `seq_req_addr` holds the start of the following 8-instruction line: (addr with its low 3 bits cleared) + 8.
- R8: A second prefetch to an entry that is still fetching issues a new tag. A reply that carries the old tag leaves the entry fetching and its line untouched.
- R9: When several entries wait to be requested, one request is issued per cycle, lowest entry number first.
- R10: `ctl_op` encodings are 0 none, 1 spill, 2 unspill, 3 call, 4 return, 5 module change. Spill of pair p gives one push cycle, starting after the next edge, with `push_pair` = p and `push_data` = {live of entry 2p+1, its address, live of entry 2p, its address}. In that word the address fields are 24 bits each, and live means not empty.
- R11: Unspill of pair p gives one `pop_valid` cycle with `pop_pair` = p. In that cycle `pop_data`, laid out as in R10, loads both entries. Live entries become fetching and are requested again. Non-live entries become empty.
- R12: A call with count n (`ctl_cnt`, 1 to 3) pushes pairs 0 to n-1 on consecutive cycles, and a return with count n pops pairs n-1 down to 0. `ctl_busy` is high while a run is in progress, and any `ctl_op` given then is ignored.
- R13: A module change, when not busy, empties all entries and suppresses the request that would leave on that edge. Replies for earlier requests are then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_valid | input | 1 | Prefetch command |
| pf_id | input | 3 | Entry to prefetch |
| pf_addr | input | 24 | Instruction address for the entry |
| br_valid | input | 1 | Branch command |
| br_id | input | 3 | Entry the branch selects |
| br_taken | input | 1 | Condition result |
| br_stall | output | 1 | Taken branch waits on a fetching entry |
| src_load | output | 1 | New instruction source loaded |
| src_addr | output | 24 | Address of the new source |
| src_line | output | 256 | Eight instructions of the new source |
| seq_req_valid | output | 1 | Sequential line request |
| seq_req_addr | output | 24 | Address of the following line |
| trap_valid | output | 1 | Branch to faulted or empty entry |
| trap_id | output | 3 | Entry that caused the trap |
| mreq_valid | output | 1 | Line request to instruction memory |
| mreq_id | output | 3 | Entry of the request |
| mreq_tag | output | 2 | Request tag |
| mreq_addr | output | 24 | Requested address |
| mrsp_valid | input | 1 | Memory reply |
| mrsp_id | input | 3 | Entry of the reply |
| mrsp_tag | input | 2 | Tag of the reply |
| mrsp_err | input | 1 | Reply reports an error |
| mrsp_line | input | 256 | Returned line |
| ctl_op | input | 3 | Stack / module operation |
| ctl_pair | input | 2 | Pair for spill or unspill |
| ctl_cnt | input | 2 | Pair count for call or return |
| ctl_busy | output | 1 | Pair run in progress |
| push_valid | output | 1 | Push one pair to the stack |
| push_pair | output | 2 | Pair being pushed |
| push_data | output | 50 | Saved pair |
| pop_valid | output | 1 | Pop one pair from the stack |
| pop_pair | output | 2 | Pair being restored |
| pop_data | input | 50 | Pair returned by the stack |

## Verification
All eight entries are prefetched with distinct addresses and then completed. Seven of them succeed and one takes an error reply. Each entry is then branched to, which separates the valid, faulted and empty paths. The line and sequential address are derived arithmetically from the entry number and address, so a swapped entry or word shows up. A stale reply after a re-prefetch, a branch on a still-fetching entry and a reply that follows a module change each tell the tag and state checks apart from a simple id match. Spill runs of length three, pops of live and non-live pairs, and an operation issued while busy show the order of pairs and the issue order of requests.

// File: rtl/bts_pkg.sv
package bts_pkg;
    localparam int ENT_N      = 8;
    localparam int ID_W       = $clog2(ENT_N);
    localparam int PAIR_N     = ENT_N / 2;
    localparam int PAIR_W     = $clog2(PAIR_N);
    localparam int ADDR_W     = 24;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 8;
    localparam int OFS_W      = $clog2(LINE_WORDS);
    localparam int LINE_W     = WORD_W * LINE_WORDS;
    localparam int TAG_W      = 2;
    localparam int CNT_W      = 2;
    localparam int OP_W       = 3;
    localparam int SAVE_W     = 2 * (ADDR_W + 1);

    typedef enum logic [1:0] {
        ST_ABSENT = 2'd0,
        ST_FETCH  = 2'd1,
        ST_FAULT  = 2'd2,
        ST_VALID  = 2'd3
    } ent_state_t;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_SPILL   = 3'd1,
        OP_UNSPILL = 3'd2,
        OP_CALL    = 3'd3,
        OP_RET     = 3'd4,
        OP_XMOD    = 3'd5
    } ctl_op_t;

    typedef struct packed {
        logic              live;
        logic [ADDR_W-1:0] addr;
    } saved_ent_t;

    typedef struct packed {
        saved_ent_t hi;
        saved_ent_t lo;
    } saved_pair_t;

    function automatic logic [ADDR_W-1:0] next_line_addr(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-OFS_W-1:0] base;
        base = a[ADDR_W-1:OFS_W] + (ADDR_W-OFS_W)'(1);
        return {base, {OFS_W{1'b0}}};
    endfunction
endpackage

// File: rtl/bts_entry_file.sv
module bts_entry_file
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_we,
    input  logic [ID_W-1:0]   pf_id,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              rsp_valid,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic              rsp_err,
    input  logic [LINE_W-1:0] rsp_line,
    input  logic              rs_we,
    input  logic [PAIR_W-1:0] rs_pair,
    input  saved_pair_t       rs_data,
    input  logic              inv_all,
    input  logic              iss_valid,
    input  logic [ID_W-1:0]   iss_id,
    output ent_state_t        ent_st   [ENT_N],
    output logic [ADDR_W-1:0] ent_addr [ENT_N],
    output logic [LINE_W-1:0] ent_line [ENT_N],
    output logic [TAG_W-1:0]  ent_tag  [ENT_N],
    output logic [ENT_N-1:0]  ent_pend
);
    for (genvar e = 0; e < ENT_N; e++) begin : g_ent
        localparam logic [ID_W-1:0]   MY_ID   = ID_W'(e);
        localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(e / 2);
        localparam bit                IS_HI   = (e % 2) == 1;

        ent_state_t        st_q;
        logic [ADDR_W-1:0] addr_q;
        logic [LINE_W-1:0] line_q;
        logic [TAG_W-1:0]  tag_q;
        logic              pend_q;
        saved_ent_t        sv;
        logic              rs_hit;
        logic              pf_hit;
        logic              rsp_hit;
        logic              iss_hit;

        assign sv      = IS_HI ? rs_data.hi : rs_data.lo;
        assign rs_hit  = rs_we && (rs_pair == MY_PAIR);
        assign pf_hit  = pf_we && (pf_id == MY_ID);
        assign iss_hit = iss_valid && (iss_id == MY_ID);
        assign rsp_hit = rsp_valid && (rsp_id == MY_ID) && (rsp_tag == tag_q)
                         && (st_q == ST_FETCH) && !pend_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q   <= ST_ABSENT;
                addr_q <= '0;
                line_q <= '0;
                tag_q  <= '0;
                pend_q <= 1'b0;
            end else if (inv_all) begin
                st_q   <= ST_ABSENT;
                tag_q  <= tag_q + TAG_W'(1);
                pend_q <= 1'b0;
            end else if (rs_hit) begin
                addr_q <= sv.addr;
                tag_q  <= tag_q + TAG_W'(1);
                st_q   <= sv.live ? ST_FETCH : ST_ABSENT;
                pend_q <= sv.live;
            end else if (pf_hit) begin
                addr_q <= pf_addr;
                tag_q  <= tag_q + TAG_W'(1);
                st_q   <= ST_FETCH;
                pend_q <= 1'b1;
            end else begin
                if (iss_hit) begin
                    pend_q <= 1'b0;
                end
                if (rsp_hit) begin
                    st_q <= rsp_err ? ST_FAULT : ST_VALID;
                    if (!rsp_err) begin
                        line_q <= rsp_line;
                    end
                end
            end
        end

        assign ent_st[e]   = st_q;
        assign ent_addr[e] = addr_q;
        assign ent_line[e] = line_q;
        assign ent_tag[e]  = tag_q;
        assign ent_pend[e] = pend_q;
    end
endmodule

// File: rtl/bts_req_arb.sv
module bts_req_arb
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ENT_N-1:0]  pending,
    input  logic [ADDR_W-1:0] ent_addr [ENT_N],
    input  logic [TAG_W-1:0]  ent_tag  [ENT_N],
    input  logic              inv_all,
    output logic              iss_valid,
    output logic [ID_W-1:0]   iss_id,
    output logic              mreq_valid,
    output logic [ID_W-1:0]   mreq_id,
    output logic [TAG_W-1:0]  mreq_tag,
    output logic [ADDR_W-1:0] mreq_addr
);
    always_comb begin
        iss_id = '0;
        for (int i = ENT_N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                iss_id = ID_W'(i);
            end
        end
        iss_valid = (|pending) && !inv_all;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mreq_valid <= 1'b0;
            mreq_id    <= '0;
            mreq_tag   <= '0;
            mreq_addr  <= '0;
        end else begin
            mreq_valid <= iss_valid;
            if (iss_valid) begin
                mreq_id   <= iss_id;
                mreq_tag  <= ent_tag[iss_id];
                mreq_addr <= ent_addr[iss_id];
            end
        end
    end
endmodule

// File: rtl/bts_pair_seq.sv
module bts_pair_seq
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   ctl_op,
    input  logic [PAIR_W-1:0] ctl_pair,
    input  logic [CNT_W-1:0]  ctl_cnt,
    output logic              busy,
    output logic              push_valid,
    output logic [PAIR_W-1:0] push_pair,
    output logic              pop_valid,
    output logic [PAIR_W-1:0] pop_pair,
    output logic              inv_all
);
    ctl_op_t           op;
    logic              active_q;
    logic              dir_push_q;
    logic              up_q;
    logic [PAIR_W-1:0] cur_q;
    logic [CNT_W-1:0]  left_q;

    assign op = ctl_op_t'(ctl_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            dir_push_q <= 1'b0;
            up_q       <= 1'b0;
            cur_q      <= '0;
            left_q     <= '0;
        end else if (active_q) begin
            if (left_q == CNT_W'(1)) begin
                active_q <= 1'b0;
            end else begin
                left_q <= left_q - CNT_W'(1);
                cur_q  <= up_q ? cur_q + PAIR_W'(1) : cur_q - PAIR_W'(1);
            end
        end else begin
            case (op)
                OP_SPILL, OP_UNSPILL: begin
                    active_q   <= 1'b1;
                    dir_push_q <= (op == OP_SPILL);
                    up_q       <= 1'b1;
                    cur_q      <= ctl_pair;
                    left_q     <= CNT_W'(1);
                end
                OP_CALL: begin
                    if (ctl_cnt != '0) begin
                        active_q   <= 1'b1;
                        dir_push_q <= 1'b1;
                        up_q       <= 1'b1;
                        cur_q      <= '0;
                        left_q     <= ctl_cnt;
                    end
                end
                OP_RET: begin
                    if (ctl_cnt != '0) begin
                        active_q   <= 1'b1;
                        dir_push_q <= 1'b0;
                        up_q       <= 1'b0;
                        cur_q      <= PAIR_W'(ctl_cnt - CNT_W'(1));
                        left_q     <= ctl_cnt;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = active_q;
    assign push_valid = active_q && dir_push_q;
    assign pop_valid  = active_q && !dir_push_q;
    assign push_pair  = cur_q;
    assign pop_pair   = cur_q;
    assign inv_all    = !active_q && (op == OP_XMOD);
endmodule

// File: rtl/bts_branch_unit.sv
module bts_branch_unit
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic [ID_W-1:0]   br_id,
    input  logic              br_taken,
    input  ent_state_t        ent_st   [ENT_N],
    input  logic [ADDR_W-1:0] ent_addr [ENT_N],
    input  logic [LINE_W-1:0] ent_line [ENT_N],
    output logic              br_stall,
    output logic              src_load,
    output logic [ADDR_W-1:0] src_addr,
    output logic [LINE_W-1:0] src_line,
    output logic              seq_req_valid,
    output logic [ADDR_W-1:0] seq_req_addr,
    output logic              trap_valid,
    output logic [ID_W-1:0]   trap_id
);
    ent_state_t sel_st;
    logic       go;
    logic       do_switch;
    logic       do_trap;

    assign sel_st    = ent_st[br_id];
    assign go        = br_valid && br_taken;
    assign do_switch = go && (sel_st == ST_VALID);
    assign do_trap   = go && ((sel_st == ST_FAULT) || (sel_st == ST_ABSENT));
    assign br_stall  = go && (sel_st == ST_FETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_load      <= 1'b0;
            src_addr      <= '0;
            src_line      <= '0;
            seq_req_valid <= 1'b0;
            seq_req_addr  <= '0;
            trap_valid    <= 1'b0;
            trap_id       <= '0;
        end else begin
            src_load      <= do_switch;
            seq_req_valid <= do_switch;
            trap_valid    <= do_trap;
            if (do_switch) begin
                src_addr     <= ent_addr[br_id];
                src_line     <= ent_line[br_id];
                seq_req_addr <= next_line_addr(ent_addr[br_id]);
            end
            if (do_trap) begin
                trap_id <= br_id;
            end
        end
    end
endmodule

// File: rtl/branch_target_store.sv
module branch_target_store
    import bts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pf_valid,
    input  logic [ID_W-1:0]   pf_id,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              br_valid,
    input  logic [ID_W-1:0]   br_id,
    input  logic              br_taken,
    output logic              br_stall,
    output logic              src_load,
    output logic [ADDR_W-1:0] src_addr,
    output logic [LINE_W-1:0] src_line,
    output logic              seq_req_valid,
    output logic [ADDR_W-1:0] seq_req_addr,
    output logic              trap_valid,
    output logic [ID_W-1:0]   trap_id,
    output logic              mreq_valid,
    output logic [ID_W-1:0]   mreq_id,
    output logic [TAG_W-1:0]  mreq_tag,
    output logic [ADDR_W-1:0] mreq_addr,
    input  logic              mrsp_valid,
    input  logic [ID_W-1:0]   mrsp_id,
    input  logic [TAG_W-1:0]  mrsp_tag,
    input  logic              mrsp_err,
    input  logic [LINE_W-1:0] mrsp_line,
    input  logic [OP_W-1:0]   ctl_op,
    input  logic [PAIR_W-1:0] ctl_pair,
    input  logic [CNT_W-1:0]  ctl_cnt,
    output logic              ctl_busy,
    output logic              push_valid,
    output logic [PAIR_W-1:0] push_pair,
    output logic [SAVE_W-1:0] push_data,
    output logic              pop_valid,
    output logic [PAIR_W-1:0] pop_pair,
    input  logic [SAVE_W-1:0] pop_data
);
    ent_state_t        ent_st   [ENT_N];
    logic [ADDR_W-1:0] ent_addr [ENT_N];
    logic [LINE_W-1:0] ent_line [ENT_N];
    logic [TAG_W-1:0]  ent_tag  [ENT_N];
    logic [ENT_N-1:0]  ent_pend;
    logic              inv_all;
    logic              iss_valid;
    logic [ID_W-1:0]   iss_id;
    saved_pair_t       out_pair;
    logic [ID_W-1:0]   lo_idx;
    logic [ID_W-1:0]   hi_idx;

    bts_pair_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl_op     (ctl_op),
        .ctl_pair   (ctl_pair),
        .ctl_cnt    (ctl_cnt),
        .busy       (ctl_busy),
        .push_valid (push_valid),
        .push_pair  (push_pair),
        .pop_valid  (pop_valid),
        .pop_pair   (pop_pair),
        .inv_all    (inv_all)
    );

    bts_entry_file i_ents (
        .clk       (clk),
        .rst       (rst),
        .pf_we     (pf_valid),
        .pf_id     (pf_id),
        .pf_addr   (pf_addr),
        .rsp_valid (mrsp_valid),
        .rsp_id    (mrsp_id),
        .rsp_tag   (mrsp_tag),
        .rsp_err   (mrsp_err),
        .rsp_line  (mrsp_line),
        .rs_we     (pop_valid),
        .rs_pair   (pop_pair),
        .rs_data   (saved_pair_t'(pop_data)),
        .inv_all   (inv_all),
        .iss_valid (iss_valid),
        .iss_id    (iss_id),
        .ent_st    (ent_st),
        .ent_addr  (ent_addr),
        .ent_line  (ent_line),
        .ent_tag   (ent_tag),
        .ent_pend  (ent_pend)
    );

    bts_req_arb i_arb (
        .clk        (clk),
        .rst        (rst),
        .pending    (ent_pend),
        .ent_addr   (ent_addr),
        .ent_tag    (ent_tag),
        .inv_all    (inv_all),
        .iss_valid  (iss_valid),
        .iss_id     (iss_id),
        .mreq_valid (mreq_valid),
        .mreq_id    (mreq_id),
        .mreq_tag   (mreq_tag),
        .mreq_addr  (mreq_addr)
    );

    bts_branch_unit i_br (
        .clk           (clk),
        .rst           (rst),
        .br_valid      (br_valid),
        .br_id         (br_id),
        .br_taken      (br_taken),
        .ent_st        (ent_st),
        .ent_addr      (ent_addr),
        .ent_line      (ent_line),
        .br_stall      (br_stall),
        .src_load      (src_load),
        .src_addr      (src_addr),
        .src_line      (src_line),
        .seq_req_valid (seq_req_valid),
        .seq_req_addr  (seq_req_addr),
        .trap_valid    (trap_valid),
        .trap_id       (trap_id)
    );

    assign lo_idx = {push_pair, 1'b0};
    assign hi_idx = {push_pair, 1'b1};

    always_comb begin
        out_pair.lo.live = (ent_st[lo_idx] != ST_ABSENT);
        out_pair.lo.addr = ent_addr[lo_idx];
        out_pair.hi.live = (ent_st[hi_idx] != ST_ABSENT);
        out_pair.hi.addr = ent_addr[hi_idx];
    end

    assign push_data = out_pair;
endmodule

// File: rtl/bts_checker.sv
module bts_checker
    import bts_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            br_valid,
    input logic            br_taken,
    input logic            br_stall,
    input logic            src_load,
    input logic            trap_valid,
    input logic            mreq_valid,
    input logic [OP_W-1:0] ctl_op,
    input logic            ctl_busy,
    input logic            push_valid,
    input logic            pop_valid
);
    AST_LOAD_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        src_load |-> $past(br_valid && br_taken)); // R4

    AST_STALL_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        br_stall |-> (br_valid && br_taken)); // R5

    AST_STALL_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        br_stall |=> !src_load); // R5

    AST_TRAP_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> $past(br_valid && br_taken)); // R6

    AST_TRAP_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(trap_valid && src_load)); // R6

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(push_valid && pop_valid)); // R12

    AST_STACK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (push_valid || pop_valid) |-> ctl_busy); // R12

    AST_XMOD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (ctl_op == OP_XMOD && !ctl_busy) |=> !mreq_valid); // R13
endmodule

bind branch_target_store bts_checker i_bts_checker (
    .clk        (clk),
    .rst        (rst),
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .br_stall   (br_stall),
    .src_load   (src_load),
    .trap_valid (trap_valid),
    .mreq_valid (mreq_valid),
    .ctl_op     (ctl_op),
    .ctl_busy   (ctl_busy),
    .push_valid (push_valid),
    .pop_valid  (pop_valid)
);

// File: tb/test_branch_target_store.sv
`timescale 1ns/1ps
module test_branch_target_store;
    import bts_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              pf_valid;
    logic [ID_W-1:0]   pf_id;
    logic [ADDR_W-1:0] pf_addr;
    logic              br_valid;
    logic [ID_W-1:0]   br_id;
    logic              br_taken;
    logic              br_stall;
    logic              src_load;
    logic [ADDR_W-1:0] src_addr;
    logic [LINE_W-1:0] src_line;
    logic              seq_req_valid;
    logic [ADDR_W-1:0] seq_req_addr;
    logic              trap_valid;
    logic [ID_W-1:0]   trap_id;
    logic              mreq_valid;
    logic [ID_W-1:0]   mreq_id;
    logic [TAG_W-1:0]  mreq_tag;
    logic [ADDR_W-1:0] mreq_addr;
    logic              mrsp_valid;
    logic [ID_W-1:0]   mrsp_id;
    logic [TAG_W-1:0]  mrsp_tag;
    logic              mrsp_err;
    logic [LINE_W-1:0] mrsp_line;
    logic [OP_W-1:0]   ctl_op;
    logic [PAIR_W-1:0] ctl_pair;
    logic [CNT_W-1:0]  ctl_cnt;
    logic              ctl_busy;
    logic              push_valid;
    logic [PAIR_W-1:0] push_pair;
    logic [SAVE_W-1:0] push_data;
    logic              pop_valid;
    logic [PAIR_W-1:0] pop_pair;
    logic [SAVE_W-1:0] pop_data;
    logic              pop_live;

    int n_chk  = 0;
    int n_fail = 0;
    logic [TAG_W-1:0] tags [ENT_N];

    always #10 clk = ~clk;

    branch_target_store i_branch_target_store (.*);

    function automatic logic [ADDR_W-1:0] addr_of(input int i);
        return ADDR_W'(24'h012345 + i * 24'h000111);
    endfunction

    function automatic logic [ADDR_W-1:0] pop_addr_of(input int i);
        return ADDR_W'(24'h300004 + i * 24'h000040);
    endfunction

    function automatic logic [LINE_W-1:0] line_of(input int i, input logic [ADDR_W-1:0] a);
        logic [LINE_W-1:0] l;
        for (int w = 0; w < LINE_WORDS; w++) begin
            l[w*WORD_W +: WORD_W] = WORD_W'(a) * 8 + WORD_W'(w) + (WORD_W'(i) << 28);
        end
        return l;
    endfunction

    function automatic logic [ADDR_W-1:0] seq_of(input logic [ADDR_W-1:0] a);
        return (a & ~ADDR_W'(LINE_WORDS - 1)) + ADDR_W'(LINE_WORDS);
    endfunction

    always_comb begin
        pop_data = {pop_live, pop_addr_of(2 * int'(pop_pair) + 1),
                    pop_live, pop_addr_of(2 * int'(pop_pair))};
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic prefetch(input int id, input logic [ADDR_W-1:0] a, input string rq);
        pf_valid = 1'b1; pf_id = ID_W'(id); pf_addr = a;
        tick();
        pf_valid = 1'b0;
        chk(mreq_valid == 1'b0, rq, "no request after first edge", LINE_W'(mreq_valid), 0);
        tick();
        chk(mreq_valid && mreq_id == ID_W'(id) && mreq_addr == a, rq, "request id/addr",
            LINE_W'({mreq_valid, mreq_id, mreq_addr}), LINE_W'({1'b1, ID_W'(id), a}));
        tags[id] = mreq_tag;
    endtask

    task automatic respond(input int id, input logic [TAG_W-1:0] t, input bit err,
                           input logic [LINE_W-1:0] l);
        mrsp_valid = 1'b1; mrsp_id = ID_W'(id); mrsp_tag = t; mrsp_err = err; mrsp_line = l;
        tick();
        mrsp_valid = 1'b0;
    endtask

    task automatic branch(input int id, input bit taken, input bit exp_stall, input string rq);
        br_valid = 1'b1; br_id = ID_W'(id); br_taken = taken;
        #1;
        chk(br_stall == exp_stall, rq, "stall", LINE_W'(br_stall), LINE_W'(exp_stall));
        tick();
        br_valid = 1'b0; br_taken = 1'b0;
    endtask

    task automatic expect_load(input int id, input logic [ADDR_W-1:0] a, input string rq);
        chk(src_load && !trap_valid && src_addr == a, rq, "source load/addr",
            LINE_W'({src_load, trap_valid, src_addr}), LINE_W'({1'b1, 1'b0, a}));
        chk(src_line == line_of(id, a), rq, "source line", src_line, line_of(id, a));
        chk(seq_req_valid && seq_req_addr == seq_of(a), "R7", "sequential request",
            LINE_W'({seq_req_valid, seq_req_addr}), LINE_W'({1'b1, seq_of(a)}));
    endtask

    task automatic expect_trap(input int id, input string rq);
        chk(trap_valid && !src_load && trap_id == ID_W'(id), rq, "trap",
            LINE_W'({trap_valid, src_load, trap_id}), LINE_W'({1'b1, 1'b0, ID_W'(id)}));
    endtask

    task automatic expect_quiet(input string rq);
        chk(!src_load && !trap_valid, rq, "no load, no trap",
            LINE_W'({src_load, trap_valid}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pf_valid = 0; pf_id = 0; pf_addr = 0;
        br_valid = 0; br_id = 0; br_taken = 0;
        mrsp_valid = 0; mrsp_id = 0; mrsp_tag = 0; mrsp_err = 0; mrsp_line = 0;
        ctl_op = 0; ctl_pair = 0; ctl_cnt = 0; pop_live = 1'b1;
        repeat (3) tick();
        chk(!mreq_valid && !src_load && !trap_valid && !push_valid && !pop_valid && !ctl_busy,
            "R1", "idle outputs in reset",
            LINE_W'({mreq_valid, src_load, trap_valid, push_valid, pop_valid, ctl_busy}), 0);
        rst = 1'b0;
        tick();
        branch(0, 1'b1, 1'b0, "R1");
        expect_trap(0, "R1");

        // R2 R3 R5: fill every entry, entry 6 gets an error reply
        for (int i = 0; i < ENT_N; i++) begin
            prefetch(i, addr_of(i), "R2");
            if (i == 2) begin
                branch(2, 1'b1, 1'b1, "R5");
                expect_quiet("R5");
            end
            respond(i, tags[i], (i == 6), line_of(i, addr_of(i)));
        end

        // R4 R6 R7: branch to each entry
        for (int i = 0; i < ENT_N; i++) begin
            branch(i, 1'b0, 1'b0, "R4");
            expect_quiet("R4");
            branch(i, 1'b1, 1'b0, (i == 6) ? "R6" : "R4");
            if (i == 6) expect_trap(6, "R3");
            else expect_load(i, addr_of(i), "R3");
            tick();
            expect_quiet("R4");
        end

        // R8: re-prefetch while fetching, stale reply ignored
        begin
            logic [TAG_W-1:0] old_tag;
            logic [ADDR_W-1:0] a2;
            a2 = 24'h0ABCD5;
            prefetch(1, 24'h045670, "R8");
            old_tag = tags[1];
            prefetch(1, a2, "R8");
            chk(tags[1] != old_tag, "R8", "new tag differs", LINE_W'(tags[1]), LINE_W'(old_tag));
            respond(1, old_tag, 1'b0, line_of(1, 24'h045670));
            branch(1, 1'b1, 1'b1, "R8");
            expect_quiet("R8");
            respond(1, tags[1], 1'b0, line_of(1, a2));
            branch(1, 1'b1, 1'b0, "R8");
            expect_load(1, a2, "R8");
            prefetch(1, addr_of(1), "R8");
            respond(1, tags[1], 1'b0, line_of(1, addr_of(1)));
        end

        // R10 R12: call with three pairs, op during busy ignored
        ctl_op = OP_CALL; ctl_cnt = 2'd3;
        tick();
        ctl_op = OP_UNSPILL; ctl_pair = 2'd3;
        for (int p = 0; p < 3; p++) begin
            logic [SAVE_W-1:0] exp_d;
            exp_d = {1'b1, addr_of(2 * p + 1), 1'b1, addr_of(2 * p)};
            chk(push_valid && !pop_valid && ctl_busy && push_pair == PAIR_W'(p), "R12",
                "push order", LINE_W'({push_valid, pop_valid, ctl_busy, push_pair}),
                LINE_W'({3'b101, PAIR_W'(p)}));
            chk(push_data == exp_d, "R10", "push data", LINE_W'(push_data), LINE_W'(exp_d));
            tick();
        end
        ctl_op = OP_NONE;
        chk(!push_valid && !pop_valid && !ctl_busy, "R12", "run ended, busy op ignored",
            LINE_W'({push_valid, pop_valid, ctl_busy}), 0);

        // R10: single spill of pair 3
        ctl_op = OP_SPILL; ctl_pair = 2'd3;
        tick();
        ctl_op = OP_NONE;
        chk(push_valid && push_pair == 2'd3 &&
            push_data == {1'b1, addr_of(7), 1'b1, addr_of(6)}, "R10", "spill pair 3",
            LINE_W'({push_valid, push_pair, push_data}),
            LINE_W'({1'b1, 2'd3, 1'b1, addr_of(7), 1'b1, addr_of(6)}));
        tick();

        // R11 R12: return with two non-live pairs
        pop_live = 1'b0;
        ctl_op = OP_RET; ctl_cnt = 2'd2;
        tick();
        ctl_op = OP_NONE;
        chk(pop_valid && pop_pair == 2'd1, "R12", "first pop", LINE_W'({pop_valid, pop_pair}),
            LINE_W'({1'b1, 2'd1}));
        tick();
        chk(pop_valid && pop_pair == 2'd0, "R12", "second pop", LINE_W'({pop_valid, pop_pair}),
            LINE_W'({1'b1, 2'd0}));
        tick();
        chk(!pop_valid && !mreq_valid, "R11", "no refetch of dead entries",
            LINE_W'({pop_valid, mreq_valid}), 0);
        branch(2, 1'b1, 1'b0, "R11");
        expect_trap(2, "R11");

        // R9 R11: unspill live pair 1, two requests lowest first
        pop_live = 1'b1;
        ctl_op = OP_UNSPILL; ctl_pair = 2'd1;
        tick();
        ctl_op = OP_NONE;
        chk(pop_valid && pop_pair == 2'd1, "R11", "unspill pop", LINE_W'({pop_valid, pop_pair}),
            LINE_W'({1'b1, 2'd1}));
        tick();
        chk(!mreq_valid, "R9", "no request yet", LINE_W'(mreq_valid), 0);
        tick();
        chk(mreq_valid && mreq_id == 3'd2 && mreq_addr == pop_addr_of(2), "R9", "first request",
            LINE_W'({mreq_valid, mreq_id, mreq_addr}), LINE_W'({1'b1, 3'd2, pop_addr_of(2)}));
        tags[2] = mreq_tag;
        tick();
        chk(mreq_valid && mreq_id == 3'd3 && mreq_addr == pop_addr_of(3), "R9", "second request",
            LINE_W'({mreq_valid, mreq_id, mreq_addr}), LINE_W'({1'b1, 3'd3, pop_addr_of(3)}));
        tags[3] = mreq_tag;
        respond(3, tags[3], 1'b0, line_of(3, pop_addr_of(3)));
        branch(3, 1'b1, 1'b0, "R11");
        expect_load(3, pop_addr_of(3), "R11");

        // R13: module change drops everything
        pf_valid = 1'b1; pf_id = 3'd4; pf_addr = 24'h077770;
        tick();
        pf_valid = 1'b0;
        ctl_op = OP_XMOD;
        tick();
        ctl_op = OP_NONE;
        chk(!mreq_valid, "R13", "request suppressed", LINE_W'(mreq_valid), 0);
        for (int t = 0; t < (1 << TAG_W); t++) begin
            respond(4, TAG_W'(t), 1'b0, line_of(4, 24'h077770));
        end
        respond(2, tags[2], 1'b0, line_of(2, pop_addr_of(2)));
        branch(4, 1'b1, 1'b0, "R13");
        expect_trap(4, "R13");
        branch(2, 1'b1, 1'b0, "R13");
        expect_trap(2, "R13");
        branch(0, 1'b1, 1'b0, "R13");
        expect_trap(0, "R13");
        tick();
        chk(!mreq_valid, "R13", "nothing requested after wipe", LINE_W'(mreq_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule